// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This block records the times at which edges occur on one input line. A free-running timestamp counter, 32 bits wide by default, is sampled into one of four stamp registers each time an edge event is recognised. An internal slot pointer picks the register for each event. The pointer moves through the slots in order and either wraps or stops at a programmable last slot.

Each slot has its own settings:
- **Edge select:** whether the slot waits for a rising edge or a falling edge.
- **Counter clear:** whether the counter is cleared once the slot has taken its stamp.

With these settings, one pass through the four slots can mix absolute times and intervals between events. An optional prescaler slows the edge stream before events are recognised. A one-shot mode stops the sequence at the last slot until software re-arms it.

Software writes one control word through a write strobe and reads it back. It reads the four stamps through a select input and the per-slot event flags directly. It clears flags by writing 1 to their bits.

Top module: `edge_stamp4`

## Requirements
- R1: Control bits [3:0] set the edge of slots 0..3: 0 recognises a rising edge and 1 a falling edge. An edge of the other polarity is ignored, and the pointer stays on the waiting slot.
- R2: Control bits [7:4] set counter clear for slots 0..3. When the active slot has clear set, its stamp takes the count before the clear and the counter is zero on the next cycle. A later event D cycles after the clearing one then stamps D-1.
- R3: Outside one-shot mode, the pointer advances by one per event and returns to slot 0 after the slot given by control bits [11:10]. These bits reset to 3.
- R4: When load enable (control bit 8) is 0, events leave every stamp unchanged but still set the flag of the active slot and still advance the pointer.
- R5: In one-shot mode (control bit 9 = 1), an event on the last slot freezes the block. Later edges change no stamp, no flag, no pointer and no counter.
- R6: Writing a control word with bit 12 set returns the pointer to slot 0 and leaves the frozen state. Bit 12 always reads back as 0.
- R7: A nonzero prescale code N in control bits [18:14] toggles the internal event line once every N rising input edges, so the edge rate is divided by 2N. Code 0 passes the synchronised input straight through. With a nonzero code, events are recognised one cycle later than in bypass.
- R8: While run (control bit 13) is 0, the counter holds. While run is 1, the counter rises by one per clock.
- R9: In bypass, an input change driven before clock edge k is recognised as an event at edge k+2. The stamp taken is the counter value just before that edge.
- R10: Each event sets the flag of its slot in `evt_flags`. The flag stays set until a 1 is written to the same bit of `flag_clr`.
- R11: After reset, the control word reads 0x00C00, and flags, pointer, counter and stamps are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous input whose edges are stamped |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 14+PW | Control word to write |
| cfg_rdata | output | 14+PW | Control word read-back (re-arm bit reads 0) |
| rd_sel | input | 2 | Selects the stamp register shown on rd_stamp |
| rd_stamp | output | CW | Selected stamp register |
| evt_flags | output | 4 | Per-slot event flags |
| flag_clr | input | 4 | Write 1 to clear the matching flags |
| slot_ptr | output | 2 | Slot the next event will use |

## Verification
The bench builds the block with the defaults: a 32-bit counter and a 5-bit prescale field. With these widths, prescale code 2 lets a few square-wave periods show a divided event rate and the extra cycle of latency. The counter never wraps within a run, so every expected stamp is an exact count measured from the cycle of the control write or of the last clearing event. Separate scenarios, each starting from reset, cover:
- mixed slot polarities with partial clearing;
- disabled loads;
- one-shot freeze and re-arm;
- a short wrap;
- a stopped counter.

// File: rtl/edge_stamp4.sv
module edge_stamp4 #(
  parameter int CW = 32,
  parameter int PW = 5,
  localparam int CFW = 14 + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sig_in,
  input  logic           cfg_we,
  input  logic [CFW-1:0] cfg_wdata,
  output logic [CFW-1:0] cfg_rdata,
  input  logic [1:0]     rd_sel,
  output logic [CW-1:0]  rd_stamp,
  output logic [3:0]     evt_flags,
  input  logic [3:0]     flag_clr,
  output logic [1:0]     slot_ptr
);
  localparam int REARM_B = 12;
  localparam logic [CFW-1:0] CFG_RST = CFW'(12'hC00);

  logic [CFW-1:0]       cfg_q;
  logic [2:0]           sync_q;
  logic [PW-1:0]        pcnt_q;
  logic                 ptgl_q, ps_d_q, frozen_q;
  logic [1:0]           ptr_q;
  logic [CW-1:0]        ctr_q;
  logic [3:0][CW-1:0]   stamp_q;
  logic [3:0]           flags_q;

  wire [3:0]    edge_sel = cfg_q[3:0];
  wire [3:0]    clr_sel  = cfg_q[7:4];
  wire          load_en  = cfg_q[8];
  wire          one_shot = cfg_q[9];
  wire [1:0]    last_slot = cfg_q[11:10];
  wire          run      = cfg_q[13];
  wire [PW-1:0] div      = cfg_q[CFW-1:14];

  wire raw_rise = sync_q[1] & ~sync_q[2];
  wire ps       = (div == '0) ? sync_q[1] : ptgl_q;
  wire hit      = edge_sel[ptr_q] ? (~ps & ps_d_q) : (ps & ~ps_d_q);
  wire halted   = frozen_q & one_shot;
  wire evt_ok   = hit & ~halted;
  wire do_clr   = evt_ok & clr_sel[ptr_q];
  wire rearm    = cfg_we & cfg_wdata[REARM_B];

  assign cfg_rdata = cfg_q;
  assign rd_stamp  = stamp_q[rd_sel];
  assign evt_flags = flags_q;
  assign slot_ptr  = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      sync_q <= '0;
      ps_d_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q          <= cfg_wdata;
        cfg_q[REARM_B] <= 1'b0;
      end
      sync_q <= {sync_q[1:0], sig_in};
      ps_d_q <= ps;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      ptgl_q <= 1'b0;
    end else if (div == '0) begin
      pcnt_q <= '0;
    end else if (raw_rise) begin
      if (pcnt_q == div - 1'b1) begin
        pcnt_q <= '0;
        ptgl_q <= ~ptgl_q;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else if (do_clr) ctr_q <= '0;
    else if (run) ctr_q <= ctr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      flags_q <= '0;
    end else begin
      if (evt_ok && load_en) stamp_q[ptr_q] <= ctr_q;
      flags_q <= (flags_q & ~flag_clr) | (evt_ok ? (4'b0001 << ptr_q) : 4'b0000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (rearm) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (evt_ok) begin
      if (ptr_q == last_slot) begin
        if (one_shot) frozen_q <= 1'b1;
        else ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) do_clr |=> ctr_q == '0); // R2
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !do_clr) |=> $stable(ctr_q)); // R8
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && !do_clr) |=> ctr_q == $past(ctr_q) + 1'b1); // R8
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (evt_ok && !load_en) |=> $stable(stamp_q)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) evt_ok |=> flags_q[$past(ptr_q)]); // R10
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (halted && !rearm) |=> $stable(ptr_q) && $stable(stamp_q)); // R5
  AST_REARM_PTR: assert property (@(posedge clk) disable iff (!rst_n) rearm |=> ptr_q == 2'd0 && !cfg_q[REARM_B]); // R6
endmodule

// File: tb/edge_stamp4_tb_top.sv
module edge_stamp4_tb_top;
  localparam int PERIOD = 10;
  localparam int CW = 32;
  localparam int PW = 5;
  localparam int CFW = 14 + PW;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, cfg_we = 1'b0;
  logic [CFW-1:0] cfg_wdata = '0;
  logic [CFW-1:0] cfg_rdata;
  logic [1:0] rd_sel = 2'd0;
  logic [CW-1:0] rd_stamp;
  logic [3:0] evt_flags;
  logic [3:0] flag_clr = 4'd0;
  logic [1:0] slot_ptr;

  typedef struct { int slot; logic [CW-1:0] val; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0, tick = 0, zero_ref = 0;
  bit done = 0;

  edge_stamp4 #(.CW(CW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rd_sel(rd_sel), .rd_stamp(rd_stamp), .evt_flags(evt_flags),
    .flag_clr(flag_clr), .slot_ptr(slot_ptr));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CFW-1:0] cw(input logic [3:0] pol, input logic [3:0] clr, input bit ld,
      input bit os, input logic [1:0] last, input bit rearm, input bit run, input logic [PW-1:0] dv);
    return {dv, run, rearm, last, os, ld, clr, pol};
  endfunction

  // monitor: pops an expected item for every new event and compares slot and stamp
  initial begin
    forever begin
      @(negedge clk);
      flag_clr = 4'd0;
      if (rst_n && evt_flags != 4'd0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5 unexpected event", evt_flags, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(evt_flags == (4'b0001 << e.slot), {e.req, " R10 flag slot"}, evt_flags, 4'b0001 << e.slot);
          rd_sel = 2'(e.slot);
          #1;
          chk(rd_stamp == e.val, {e.req, " stamp"}, rd_stamp, e.val);
        end
        flag_clr = evt_flags;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sig_in = 1'b0; cfg_we = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [CFW-1:0] w, input bit set_ref);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    if (set_ref) zero_ref = tick;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hit(input logic lvl, input int slot, input bit exp_on, input bit zero_val,
                     input bit clr, input int extra, input string req);
    int t;
    @(negedge clk);
    sig_in = lvl;
    t = tick;
    if (exp_on) begin
      exp_t e;
      e.slot = slot;
      e.val = zero_val ? '0 : CW'(t - zero_ref + 1 + extra);
      e.req = req;
      q.push_back(e);
    end
    if (clr) zero_ref = t + 2 + extra;
    repeat (7) @(negedge clk);
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, {req, " queue drained"}, q.size(), 0);
    chk(evt_flags == 4'd0, "R10 flags cleared", evt_flags, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    chk(cfg_rdata == 19'h00C00, "R11 control reset", cfg_rdata, 19'h00C00);
    chk(evt_flags == 4'd0, "R11 flags reset", evt_flags, 0);
    chk(slot_ptr == 2'd0, "R11 pointer reset", slot_ptr, 0);
    chk(rd_stamp == '0, "R11 stamp reset", rd_stamp, 0);

    // R1 R3 R9: absolute stamps on rising edges, wrap after slot 3
    wcfg(cw(4'b0000, 4'b0000, 1, 0, 2'd3, 0, 1, 5'd0), 1);
    for (int i = 0; i < 5; i++) begin
      hit(1'b1, i % 4, 1, 0, 0, 0, "R9 R3 absolute");
      hit(1'b0, 0, 0, 0, 0, 0, "R1");
    end
    drained("R3");
    chk(slot_ptr == 2'd1, "R3 wrap pointer", slot_ptr, 1);

    // R1 R2: slot 2 falling, clear on slots 0 and 2
    do_reset();
    wcfg(cw(4'b0100, 4'b0101, 1, 0, 2'd3, 0, 1, 5'd0), 1);
    hit(1'b1, 0, 1, 0, 1, 0, "R2 clear slot0");
    hit(1'b0, 1, 0, 0, 0, 0, "R1 ignored fall");
    chk(slot_ptr == 2'd1, "R1 wrong polarity ignored", slot_ptr, 1);
    hit(1'b1, 1, 1, 0, 0, 0, "R2 interval");
    hit(1'b0, 2, 1, 0, 1, 0, "R1 falling slot2");
    hit(1'b1, 3, 1, 0, 0, 0, "R2 after clear");
    drained("R2");

    // R4: loads disabled, flags still raised
    do_reset();
    wcfg(cw(4'b0000, 4'b0000, 0, 0, 2'd3, 0, 1, 5'd0), 1);
    hit(1'b1, 0, 1, 1, 0, 0, "R4 no load");
    hit(1'b0, 0, 0, 0, 0, 0, "R4");
    hit(1'b1, 1, 1, 1, 0, 0, "R4 no load");
    drained("R4");
    chk(slot_ptr == 2'd2, "R4 pointer advances", slot_ptr, 2);

    // R5 R6: one-shot with last slot 1, then re-arm
    do_reset();
    wcfg(cw(4'b0000, 4'b0000, 1, 1, 2'd1, 0, 1, 5'd0), 1);
    hit(1'b1, 0, 1, 0, 0, 0, "R5 one-shot");
    hit(1'b0, 0, 0, 0, 0, 0, "R5");
    hit(1'b1, 1, 1, 0, 0, 0, "R5 one-shot");
    hit(1'b0, 0, 0, 0, 0, 0, "R5");
    hit(1'b1, 0, 0, 0, 0, 0, "R5 frozen");
    hit(1'b0, 0, 0, 0, 0, 0, "R5");
    drained("R5");
    chk(slot_ptr == 2'd1, "R5 frozen pointer", slot_ptr, 1);
    rd_sel = 2'd2; #1;
    chk(rd_stamp == '0, "R5 slot2 untouched", rd_stamp, 0);
    wcfg(cw(4'b0000, 4'b0000, 1, 1, 2'd1, 1, 1, 5'd0), 0);
    chk(cfg_rdata[12] == 1'b0, "R6 re-arm reads 0", cfg_rdata[12], 0);
    chk(slot_ptr == 2'd0, "R6 pointer to slot0", slot_ptr, 0);
    hit(1'b1, 0, 1, 0, 0, 0, "R6 after re-arm");
    drained("R6");

    // R3: continuous with last slot 1
    do_reset();
    wcfg(cw(4'b0000, 4'b0000, 1, 0, 2'd1, 0, 1, 5'd0), 1);
    for (int i = 0; i < 3; i++) begin
      hit(1'b1, i % 2, 1, 0, 0, 0, "R3 short wrap");
      hit(1'b0, 0, 0, 0, 0, 0, "R3");
    end
    drained("R3");
    chk(slot_ptr == 2'd1, "R3 short wrap pointer", slot_ptr, 1);

    // R8: counter stopped
    do_reset();
    wcfg(cw(4'b0000, 4'b0000, 1, 0, 2'd3, 0, 0, 5'd0), 1);
    hit(1'b1, 0, 1, 1, 0, 0, "R8 counter held");
    drained("R8");

    // R7: prescale code 2, slot0 rising, slot1 falling
    do_reset();
    wcfg(cw(4'b0010, 4'b0000, 1, 0, 2'd3, 0, 1, 5'd2), 1);
    hit(1'b1, 0, 0, 0, 0, 0, "R7");
    hit(1'b0, 0, 0, 0, 0, 0, "R7");
    hit(1'b1, 0, 1, 0, 0, 1, "R7 divided rise");
    hit(1'b0, 0, 0, 0, 0, 0, "R7");
    hit(1'b1, 0, 0, 0, 0, 0, "R7");
    hit(1'b0, 0, 0, 0, 0, 0, "R7");
    hit(1'b1, 1, 1, 0, 0, 1, "R7 divided fall");
    hit(1'b0, 0, 0, 0, 0, 0, "R7");
    drained("R7");
    chk(slot_ptr == 2'd2, "R7 two events only", slot_ptr, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule